// File: doc/BRIEF.md
# Real-Time Clock Low-Speed Clock Selector

This block produces the slow timebase that a real-time clock counts on. It picks one of two sources. The first is an internal RC oscillator path, which passes through an optional fixed pre-divider and then a 5-bit programmable divider. The second is an external 32 kHz crystal, which passes straight through. All clocks are modelled as single-cycle enable strobes in one system clock domain. The selected strobe is registered and driven out, and a second output carries a copy of it that software can gate.

Software reaches three word registers over a simple register bus: control, divider and output gate. The control register is protected by a key. A write changes its fields only when the upper half of the written word holds the key value. A hardware fallback clears the source select when the external oscillator reports a failure, unless software has set the bypass bit.

Top module: `rtc_lsclk_sel`

## Requirements
- R1: A write to the control register (word address 0) with data bits 31:16 equal to 16'h16AA loads bit 0 (source select, 1 = external), bit 4 (external oscillator enable) and bit 15 (fallback bypass) from the written data.
- R2: A write to the control register whose bits 31:16 differ from 16'h16AA leaves all three control fields unchanged.
- R3: Register reads return 0 in bits 31:16 and in every bit that holds no field. Control reads show bits 0, 4 and 15. The divider (word address 1) reads back in bits 4:0 and the gate (word address 2) in bit 0.
- R4: With bit 0 set, every external strobe appears on `lsclk_tick` exactly one cycle later, undivided, whatever the divider holds.
- R5: With bit 0 clear and an internal strobe every cycle, `lsclk_tick` pulses with a period of FIXED_PREDIV × (divider + 1) cycles.
- R6: The divider ends of its range behave as stated in R5: a value of 0 gives the pre-divide alone, and a value of 31 gives 32 times the pre-divide.
- R7: `lsclk_out_tick` equals `lsclk_tick` when gate bit 0 is 1, and stays 0 when it is 0.
- R8: When `ext_osc_fail` is high and the bypass bit is 0, the source select bit is cleared on the next edge and the output falls back to the internal path. Bits 4 and 15 are kept.
- R9: When the bypass bit is 1, `ext_osc_fail` has no effect on the source select bit.
- R10: `ext_osc_en` follows control bit 4.
- R11: After reset, all three registers read 0 and both strobe outputs and `ext_osc_en` are 0.
- R12: The fallback takes priority over a keyed control write in the same cycle that sets bit 0. The bypass value used for that decision is the one held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_osc_tick | input | 1 | Internal RC oscillator enable strobe |
| ext_osc_tick | input | 1 | External crystal enable strobe |
| ext_osc_fail | input | 1 | External oscillator failure indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ext_osc_en | output | 1 | Enable for the external oscillator |
| lsclk_tick | output | 1 | Selected low-speed strobe |
| lsclk_out_tick | output | 1 | Gated copy of the selected strobe |

## Verification
The hardest case to reach is the collision between a failure report and a keyed control write in the same cycle. It needs a fail pulse on exactly the edge that writes the register. The bench gets there by raising `ext_osc_fail` and the write strobe at the same falling edge, while the bypass bit still holds 0. Divider periods are measured only from the second output pulse after a change, so that a counter value left over from the old setting cannot distort the result.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
   localparam logic [15:0] LSC_KEY    = 16'h16AA;
   localparam int unsigned LSC_ADDR_W = 2;
   localparam logic [LSC_ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [LSC_ADDR_W-1:0] A_DIV  = 2'd1;
   localparam logic [LSC_ADDR_W-1:0] A_GATE = 2'd2;
   localparam int unsigned B_SRC = 0;
   localparam int unsigned B_XEN = 4;
   localparam int unsigned B_BYP = 15;

   typedef struct packed {
      logic bypass;
      logic xosc_en;
      logic src_ext;
   } lsc_ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int unsigned DIV_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [LSC_ADDR_W-1:0] addr,
   input  logic [31:0]           wdata,
   input  logic                  ext_fail,
   output logic [31:0]           rdata,
   output lsc_ctrl_t             ctrl,
   output logic [DIV_W-1:0]      div,
   output logic                  gate_en
);
   logic key_ok;
   logic fall_back;

   assign key_ok    = (wdata[31:16] == LSC_KEY);
   assign fall_back = ext_fail && !ctrl.bypass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         div     <= '0;
         gate_en <= 1'b0;
      end else begin
         if (wr && addr == A_CTRL && key_ok) begin
            ctrl.bypass  <= wdata[B_BYP];
            ctrl.xosc_en <= wdata[B_XEN];
            ctrl.src_ext <= wdata[B_SRC];
         end
         if (fall_back) begin
            ctrl.src_ext <= 1'b0;
         end
         if (wr && addr == A_DIV) begin
            div <= wdata[DIV_W-1:0];
         end
         if (wr && addr == A_GATE) begin
            gate_en <= wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CTRL: begin
            rdata[B_BYP] = ctrl.bypass;
            rdata[B_XEN] = ctrl.xosc_en;
            rdata[B_SRC] = ctrl.src_ext;
         end
         A_DIV:   rdata[DIV_W-1:0] = div;
         A_GATE:  rdata[0] = gate_en;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/lsclk_prediv.sv
module lsclk_prediv #(
   parameter int unsigned FACTOR = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_tick,
   output logic out_tick
);
   generate
      if (FACTOR <= 1) begin : g_bypass
         assign out_tick = in_tick;
      end else begin : g_count
         localparam int unsigned CW = $clog2(FACTOR);
         localparam logic [CW-1:0] LAST = CW'(FACTOR - 1);
         logic [CW-1:0] cnt;

         assign out_tick = in_tick && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (in_tick) begin
               cnt <= out_tick ? '0 : cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lsclk_divider.sv
module lsclk_divider #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_tick,
   input  logic [DIV_W-1:0] div,
   output logic             out_tick
);
   logic [DIV_W-1:0] cnt;

   assign out_tick = in_tick && (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (in_tick) begin
         cnt <= out_tick ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_lsclk_sel.sv
module rtc_lsclk_sel
   import lsclk_pkg::*;
#(
   parameter int unsigned FIXED_PREDIV = 32,
   parameter int unsigned DIV_W        = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        int_osc_tick,
   input  logic        ext_osc_tick,
   input  logic        ext_osc_fail,
   input  logic        reg_wr,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        ext_osc_en,
   output logic        lsclk_tick,
   output logic        lsclk_out_tick
);
   generate
      if (FIXED_PREDIV < 1) begin : g_bad_prediv
         $error("FIXED_PREDIV must be at least 1");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_divw
         $error("DIV_W must lie in 1..16");
      end
   endgenerate

   lsc_ctrl_t        ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic             gate_q;
   logic             pre_tick;
   logic             int_tick;
   logic             sel_tick;

   lsclk_regs #(.DIV_W(DIV_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .ext_fail (ext_osc_fail),
      .rdata    (reg_rdata),
      .ctrl     (ctrl_q),
      .div      (div_q),
      .gate_en  (gate_q)
   );

   lsclk_prediv #(.FACTOR(FIXED_PREDIV)) u_prediv (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (int_osc_tick),
      .out_tick (pre_tick)
   );

   lsclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (pre_tick),
      .div      (div_q),
      .out_tick (int_tick)
   );

   assign sel_tick   = ctrl_q.src_ext ? ext_osc_tick : int_tick;
   assign ext_osc_en = ctrl_q.xosc_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsclk_tick     <= 1'b0;
         lsclk_out_tick <= 1'b0;
      end else begin
         lsclk_tick     <= sel_tick;
         lsclk_out_tick <= sel_tick && gate_q;
      end
   end
endmodule

// File: rtl/rtc_lsclk_sel_chk.sv
module rtc_lsclk_sel_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        int_osc_tick,
   input logic        ext_osc_tick,
   input logic        ext_osc_fail,
   input logic        reg_wr,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        lsclk_tick,
   input logic        lsclk_out_tick,
   input logic        src_ext,
   input logic        xosc_en,
   input logic        bypass
);
   AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      lsclk_out_tick |-> lsclk_tick); // R7

   AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_osc_fail && !bypass) |=> !src_ext); // R8

   AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_osc_fail && bypass && !reg_wr) |=> $stable(src_ext)); // R9

   AST_NOKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && reg_wdata[31:16] != 16'h16AA && !ext_osc_fail)
      |=> ($stable(src_ext) && $stable(xosc_en) && $stable(bypass))); // R2

   AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ext && ext_osc_tick) |=> lsclk_tick); // R4

   AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_ext && !int_osc_tick) |=> !lsclk_tick); // R5

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31:16] == 16'h0000); // R3
endmodule

bind rtc_lsclk_sel rtc_lsclk_sel_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .int_osc_tick   (int_osc_tick),
   .ext_osc_tick   (ext_osc_tick),
   .ext_osc_fail   (ext_osc_fail),
   .reg_wr         (reg_wr),
   .reg_addr       (reg_addr),
   .reg_wdata      (reg_wdata),
   .reg_rdata      (reg_rdata),
   .lsclk_tick     (lsclk_tick),
   .lsclk_out_tick (lsclk_out_tick),
   .src_ext        (ctrl_q.src_ext),
   .xosc_en        (ctrl_q.xosc_en),
   .bypass         (ctrl_q.bypass)
);

// File: tb/rtc_lsclk_sel_bench.sv
module rtc_lsclk_sel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        int_on = 1'b1;
   logic        ext_osc_fail = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ext_osc_en, lsclk_tick, lsclk_out_tick;
   logic        man_pulse = 1'b0;
   int          ext_per = 7;
   int          ext_cnt = 0;
   logic        ext_osc_tick;
   int          total = 0;
   int          bad = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (ext_per == 0) ext_cnt <= 0;
      else ext_cnt <= (ext_cnt >= ext_per - 1) ? 0 : ext_cnt + 1;
   end
   assign ext_osc_tick = man_pulse | ((ext_per != 0) && (ext_cnt == ext_per - 1));

   rtc_lsclk_sel u_rtc_lsclk_sel (
      .clk(clk), .rst_n(rst_n), .int_osc_tick(int_on), .ext_osc_tick(ext_osc_tick),
      .ext_osc_fail(ext_osc_fail), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_osc_en(ext_osc_en),
      .lsclk_tick(lsclk_tick), .lsclk_out_tick(lsclk_out_tick)
   );

   // {src_ext, divider, external period, expected output period}
   localparam int NV = 6;
   localparam int VEC [NV][4] = '{
      '{0, 0, 7, 32}, '{0, 1, 7, 64}, '{0, 3, 7, 128},
      '{0, 31, 7, 1024}, '{1, 7, 5, 5}, '{1, 0, 3, 3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_tick();
      for (int n = 0; n < 5000; n++) begin
         @(negedge clk);
         if (lsclk_tick) break;
      end
   endtask

   task automatic measure(output int per);
      int n;
      wait_tick();
      wait_tick();
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!lsclk_tick && n < 5000);
      per = n;
   endtask

   task automatic pulse_fail();
      @(negedge clk);
      ext_osc_fail = 1'b1;
      @(negedge clk);
      ext_osc_fail = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 190000; c++) @(negedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int per, n_out, n_gate;
      repeat (3) @(negedge clk);
      // R11 reset state
      rd(2'd0, d); chk("R11 ctrl", d, 32'h0);
      rd(2'd1, d); chk("R11 div", d, 32'h0);
      rd(2'd2, d); chk("R11 gate", d, 32'h0);
      chk("R11 outs", {ext_osc_en, lsclk_tick, lsclk_out_tick}, 3'b000);
      rst_n = 1'b1;

      // R4 R5 R6 vector table
      for (int i = 0; i < NV; i++) begin
         ext_per = VEC[i][2];
         wr(2'd1, 32'(VEC[i][1]));
         wr(2'd0, VEC[i][0] != 0 ? 32'h16AA_0011 : 32'h16AA_0000);
         measure(per);
         chk($sformatf("R5 R6 R4 vec%0d period", i), 32'(per), 32'(VEC[i][3]));
      end

      // R1 R3 keyed write, reads of unused bits
      wr(2'd0, 32'h16AA_FFFF);
      rd(2'd0, d); chk("R1 R3 ctrl readback", d, 32'h0000_8011);
      chk("R10 xosc_en set", ext_osc_en, 1'b1);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d); chk("R3 div readback", d, 32'h0000_001F);
      // R2 wrong key
      wr(2'd0, 32'h16AB_0000);
      rd(2'd0, d); chk("R2 bad key ignored", d, 32'h0000_8011);
      wr(2'd0, 32'h0000_0000);
      rd(2'd0, d); chk("R2 zero key ignored", d, 32'h0000_8011);

      // R9 bypass set: fail ignored
      pulse_fail();
      rd(2'd0, d); chk("R9 bypass holds src", d, 32'h0000_8011);

      // R10 ext enable clear
      wr(2'd0, 32'h16AA_0001);
      chk("R10 xosc_en clear", ext_osc_en, 1'b0);

      // R7 gate off then on
      ext_per = 5;
      wr(2'd2, 32'h0);
      n_out = 0; n_gate = 0;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         n_out += int'(lsclk_tick); n_gate += int'(lsclk_out_tick);
      end
      chk("R7 gate off", 32'(n_gate), 32'd0);
      chk("R7 ticks present", 32'(n_out), 32'd20);
      wr(2'd2, 32'h1);
      n_out = 0; n_gate = 0;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         n_out += int'(lsclk_tick); n_gate += int'(lsclk_out_tick);
         if (lsclk_tick !== lsclk_out_tick) n_gate += 1000;
      end
      chk("R7 gate on", 32'(n_gate), 32'(n_out));

      // R4 single-strobe latency
      ext_per = 0;
      repeat (3) @(negedge clk);
      man_pulse = 1'b1;
      #1 chk("R4 before", lsclk_tick, 1'b0);
      @(negedge clk);
      man_pulse = 1'b0;
      chk("R4 one cycle later", lsclk_tick, 1'b1);
      @(negedge clk);
      chk("R4 single pulse", lsclk_tick, 1'b0);

      // R8 fallback without bypass
      ext_per = 5;
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h16AA_0011);
      pulse_fail();
      rd(2'd0, d); chk("R8 src cleared", d, 32'h0000_0010);
      measure(per);
      chk("R8 internal period", 32'(per), 32'd32);

      // R12 fail with a keyed write that sets bit 0
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h16AA_8011; ext_osc_fail = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ext_osc_fail = 1'b0; reg_wdata = '0;
      rd(2'd0, d); chk("R12 fail beats write", d, 32'h0000_8010);

      finish_run();
   end
endmodule